// File: doc/BRIEF.md
# AUX Transaction Retry Sequencer

This block sits between a host that wants one auxiliary-channel transfer done and the low-level engine that serialises it on the wire. The host presents a command code, a 20-bit target address, a byte count (1 to 16, carried as count minus one) and up to 16 bytes of write payload with a one-cycle `req_valid` strobe. The sequencer accepts that request only while it is in its idle state. It then waits for the channel to go quiet, requests and waits for ownership, confirms that a sink is attached, and for writes loads the whole 16-byte transmit buffer. After that it runs up to `MAX_TRIES` attempts. Each attempt is a channel reset pulse, a pause before every attempt except the first, a start strobe, and a wait for the engine to finish.

Every wait is measured in microseconds from a free-running prescaler of `TICK_DIV` clocks. When the request ends, the sequencer drops ownership, pulses `done` for one cycle and presents a 2-bit result: 0 success, 1 channel busy, 2 no sink, 3 remote I/O failure. A successful read also returns the requested bytes on `rd_data`.

States and transitions:
- IDLE→WAIT_IDLE on `req_valid`.
- WAIT_IDLE→OWN when `chan_busy` is low; WAIT_IDLE→DONE (busy) when the idle limit expires.
- OWN→SINK on `own_gnt`; OWN→DONE (busy) when the grant limit expires.
- SINK→DONE (no sink) when `sink_present` is low. Otherwise SINK goes to LOAD for writes or to RST for reads.
- LOAD→RST after the last word.
- RST→START on the first attempt, RST→GAP on later attempts; GAP→START when the gap expires.
- START→WAIT_XFER.
- WAIT_XFER→CHECK when `xfer_busy` falls; WAIT_XFER→DONE (remote) when the transfer limit expires.
- CHECK→UNLOAD (clean read), CHECK→DONE (clean write), CHECK→RST (error with attempts left) or CHECK→DONE (remote, attempts used up).
- UNLOAD→DONE after the last word; DONE→IDLE.

Top module: `aux_xfer_seq`

## Requirements
- R1: While `chan_busy` stays high, the request ends with result 1 after about `IDLE_US` microseconds, and neither `own_req`, `chan_rst` nor `xfer_start` is ever raised.
- R2: If `own_gnt` does not arrive within `GRANT_US` microseconds of `own_req` rising, the request ends with result 1 and `own_req` is low again.
- R3: With `sink_present` low after the grant, the request ends with result 2 and no `xfer_start` is issued.
- R4: For a command whose bit 0 is 0 (write), all four 32-bit transmit words are written before the first `xfer_start`. Word w carries payload bytes 4w..4w+3, with the lowest byte in bits 7:0. For a read (bit 0 = 1), no transmit word is written.
- R5: At each `xfer_start`, `eng_cmd` equals the request command, `eng_addr` the request address, and `eng_len` the byte count minus one.
- R6: Each attempt is one `chan_rst` pulse followed by one `xfer_start`. With k failing attempts the number of attempts is min(k+1, `MAX_TRIES`).
- R7: The first attempt starts the cycle after its reset pulse. Every later attempt waits at least `GAP_US`-1 whole microseconds between reset and start.
- R8: If `xfer_busy` stays high for `XFER_US` microseconds after a start, the request ends at once with result 3 and no further attempt is made.
- R9: An attempt succeeds only when `xfer_status` is all zero. If every attempt returns nonzero status, the result is 3.
- R10: After a successful read, `rd_data` byte b holds received byte b for b ≤ count-1, and every higher byte is zero. Receive word w holds bytes 4w..4w+3, lowest byte in bits 7:0.
- R11: `own_req` is low in the cycle `done` is high, whatever the result.
- R12: `done` is high for exactly one cycle per accepted request, and a `req_valid` raised while a request is in flight has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_cmd | input | 4 | Command code; bit 0 set means read |
| req_addr | input | 20 | Target address |
| req_len | input | 4 | Byte count minus one |
| req_wdata | input | 128 | Write payload, byte 0 in bits 7:0 |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 busy, 2 no sink, 3 remote failure |
| rd_data | output | 128 | Read bytes, unrequested bytes zero |
| chan_busy | input | 1 | Channel still finishing earlier work |
| own_req | output | 1 | Channel ownership request |
| own_gnt | input | 1 | Channel ownership grant |
| sink_present | input | 1 | A sink is attached |
| eng_cmd | output | 4 | Command field to the engine |
| eng_addr | output | 20 | Address field to the engine |
| eng_len | output | 4 | Count-minus-one field to the engine |
| tx_we | output | 1 | Transmit word write strobe |
| tx_idx | output | 2 | Transmit word index |
| tx_word | output | 32 | Transmit word data |
| chan_rst | output | 1 | Channel reset pulse |
| xfer_start | output | 1 | Attempt start strobe |
| xfer_busy | input | 1 | Engine is running an attempt |
| xfer_status | input | 8 | Reply and error flags of the last attempt |
| rx_idx | output | 2 | Receive word index |
| rx_word | input | 32 | Receive word at `rx_idx` |

## Verification
The bench builds the sequencer with `TICK_DIV`=4, 6-microsecond idle, grant and transfer limits, a 5-microsecond retry gap and `MAX_TRIES`=4. With these values every timeout ends within a few dozen cycles, and the full retry budget can be used up in a short run. A sweep over all 16 byte counts for both a write and a read command checks buffer loading, field passing and read masking. A second sweep over 0 to 5 failing attempts steps past the retry limit and measures each inter-attempt gap against the microsecond arithmetic.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WAIT_IDLE,
        S_OWN,
        S_SINK,
        S_LOAD,
        S_RST,
        S_GAP,
        S_START,
        S_WAIT_XFER,
        S_CHECK,
        S_UNLOAD,
        S_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        RES_OK     = 2'd0,
        RES_BUSY   = 2'd1,
        RES_NODEV  = 2'd2,
        RES_REMOTE = 2'd3
    } seq_result_t;

endpackage

// File: rtl/aux_us_tick.sv
module aux_us_tick #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == CW'(DIV - 1))
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == CW'(DIV - 1));
endmodule

// File: rtl/aux_us_timer.sv
module aux_us_timer #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (tick && (count != {CW{1'b1}}))
            count <= count + 1'b1;
    end
endmodule

// File: rtl/aux_xfer_seq.sv
module aux_xfer_seq
    import aux_seq_pkg::*;
#(
    parameter int TICK_DIV  = 100,
    parameter int IDLE_US   = 1000,
    parameter int GRANT_US  = 1000,
    parameter int XFER_US   = 1000,
    parameter int GAP_US    = 400,
    parameter int MAX_TRIES = 32,
    parameter int ADDR_W    = 20,
    parameter int CMD_W     = 4,
    parameter int LEN_W     = 4,
    parameter int WORD_W    = 32,
    parameter int STAT_W    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [CMD_W-1:0]          req_cmd,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [LEN_W-1:0]          req_len,
    input  logic [(8<<LEN_W)-1:0]     req_wdata,
    output logic                      done,
    output logic [1:0]                result,
    output logic [(8<<LEN_W)-1:0]     rd_data,
    input  logic                      chan_busy,
    output logic                      own_req,
    input  logic                      own_gnt,
    input  logic                      sink_present,
    output logic [CMD_W-1:0]          eng_cmd,
    output logic [ADDR_W-1:0]         eng_addr,
    output logic [LEN_W-1:0]          eng_len,
    output logic                      tx_we,
    output logic [$clog2((8<<LEN_W)/WORD_W)-1:0] tx_idx,
    output logic [WORD_W-1:0]         tx_word,
    output logic                      chan_rst,
    output logic                      xfer_start,
    input  logic                      xfer_busy,
    input  logic [STAT_W-1:0]         xfer_status,
    output logic [$clog2((8<<LEN_W)/WORD_W)-1:0] rx_idx,
    input  logic [WORD_W-1:0]         rx_word
);
    localparam int BYTES   = 1 << LEN_W;
    localparam int BUF_W   = 8 * BYTES;
    localparam int WORDS   = BUF_W / WORD_W;
    localparam int IDX_W   = $clog2(WORDS);
    localparam int LIM_A   = (IDLE_US > GRANT_US) ? IDLE_US : GRANT_US;
    localparam int LIM_B   = (XFER_US > GAP_US) ? XFER_US : GAP_US;
    localparam int LIM_MAX = (LIM_A > LIM_B) ? LIM_A : LIM_B;
    localparam int TW      = $clog2(LIM_MAX + 1) + 1;
    localparam int TRY_W   = $clog2(MAX_TRIES + 1);

    seq_state_t  state_q, state_d;
    seq_result_t res_q, res_d;

    logic [CMD_W-1:0]  cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic [BUF_W-1:0]  wdata_q;
    logic [BUF_W-1:0]  rbuf_q;
    logic [BUF_W-1:0]  byte_mask;
    logic [IDX_W-1:0]  idx_q;
    logic [TRY_W-1:0]  tries_q;
    logic              us_tick;
    logic [TW-1:0]     us_count;
    logic [TW-1:0]     us_limit;
    logic              expired;
    logic              is_read;

    aux_us_tick #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (us_tick)
    );

    aux_us_timer #(.CW(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q != state_d),
        .tick  (us_tick),
        .count (us_count)
    );

    assign is_read = cmd_q[0];

    always_comb begin
        unique case (state_q)
            S_WAIT_IDLE: us_limit = TW'(IDLE_US);
            S_OWN:       us_limit = TW'(GRANT_US);
            S_GAP:       us_limit = TW'(GAP_US);
            S_WAIT_XFER: us_limit = TW'(XFER_US);
            default:     us_limit = '0;
        endcase
    end
    assign expired = (us_count >= us_limit);

    // next-state and result selection
    always_comb begin
        state_d = state_q;
        res_d   = res_q;
        unique case (state_q)
            S_IDLE:      if (req_valid) state_d = S_WAIT_IDLE;
            S_WAIT_IDLE: begin
                if (!chan_busy)  state_d = S_OWN;
                else if (expired) begin state_d = S_DONE; res_d = RES_BUSY; end
            end
            S_OWN: begin
                if (own_gnt)      state_d = S_SINK;
                else if (expired) begin state_d = S_DONE; res_d = RES_BUSY; end
            end
            S_SINK: begin
                if (!sink_present) begin state_d = S_DONE; res_d = RES_NODEV; end
                else if (is_read)  state_d = S_RST;
                else               state_d = S_LOAD;
            end
            S_LOAD:      if (idx_q == IDX_W'(WORDS - 1)) state_d = S_RST;
            S_RST:       state_d = (tries_q == '0) ? S_START : S_GAP;
            S_GAP:       if (expired) state_d = S_START;
            S_START:     state_d = S_WAIT_XFER;
            S_WAIT_XFER: begin
                if (!xfer_busy)   state_d = S_CHECK;
                else if (expired) begin state_d = S_DONE; res_d = RES_REMOTE; end
            end
            S_CHECK: begin
                if (xfer_status == '0) begin
                    if (is_read) state_d = S_UNLOAD;
                    else begin state_d = S_DONE; res_d = RES_OK; end
                end else if (tries_q == TRY_W'(MAX_TRIES - 1)) begin
                    state_d = S_DONE; res_d = RES_REMOTE;
                end else begin
                    state_d = S_RST;
                end
            end
            S_UNLOAD: if (idx_q == IDX_W'(WORDS - 1)) begin
                state_d = S_DONE; res_d = RES_OK;
            end
            S_DONE:      state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            res_q   <= RES_OK;
        end else begin
            state_q <= state_d;
            res_q   <= res_d;
        end
    end

    // request latch, counters and receive buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            addr_q  <= '0;
            len_q   <= '0;
            wdata_q <= '0;
            rbuf_q  <= '0;
            idx_q   <= '0;
            tries_q <= '0;
        end else begin
            if (state_q == S_IDLE && req_valid) begin
                cmd_q   <= req_cmd;
                addr_q  <= req_addr;
                len_q   <= req_len;
                wdata_q <= req_wdata;
                rbuf_q  <= '0;
                tries_q <= '0;
            end
            if (state_q != state_d)
                idx_q <= '0;
            else if (state_q == S_LOAD || state_q == S_UNLOAD)
                idx_q <= idx_q + 1'b1;
            if (state_q == S_UNLOAD && state_d == S_DONE)
                idx_q <= '0;
            if (state_q == S_LOAD && state_d == S_RST)
                idx_q <= '0;
            if (state_q == S_UNLOAD)
                rbuf_q[idx_q*WORD_W +: WORD_W] <= rx_word;
            if (state_q == S_CHECK && xfer_status != '0)
                tries_q <= tries_q + 1'b1;
        end
    end

    generate
        for (genvar b = 0; b < BYTES; b++) begin : g_mask
            assign byte_mask[b*8 +: 8] = (b <= int'(len_q)) ? 8'hFF : 8'h00;
        end
    endgenerate

    // outputs
    always_comb begin
        own_req    = 1'b0;
        tx_we      = 1'b0;
        chan_rst   = 1'b0;
        xfer_start = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            S_OWN, S_SINK, S_RST, S_GAP,
            S_WAIT_XFER, S_CHECK, S_UNLOAD: own_req = 1'b1;
            S_LOAD:  begin own_req = 1'b1; tx_we = 1'b1; end
            S_START: begin own_req = 1'b1; xfer_start = 1'b1; end
            S_DONE:  done = 1'b1;
            default: ;
        endcase
        if (state_q == S_RST) chan_rst = 1'b1;
    end

    assign result   = res_q;
    assign rd_data  = rbuf_q & byte_mask;
    assign eng_cmd  = cmd_q;
    assign eng_addr = addr_q;
    assign eng_len  = len_q;
    assign tx_idx   = idx_q;
    assign rx_idx   = idx_q;
    assign tx_word  = wdata_q[idx_q*WORD_W +: WORD_W];

    // R11: ownership is never held on the completion cycle
    a_r11_release_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !own_req);

    // R12: completion is a single-cycle pulse
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: an attempt only starts while ownership is both requested and granted
    a_r6_start_owned: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> (own_req && own_gnt));

    // R4: transmit words are only written for write commands
    a_r4_load_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        tx_we |-> (eng_cmd[0] == 1'b0));

    // R8: a start strobe is never repeated in the following cycle
    a_r8_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    // R7: a start never coincides with a channel reset
    a_r7_rst_then_start: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst |-> !xfer_start);
endmodule

// File: tb/aux_xfer_seq_bench.sv
module aux_xfer_seq_bench;
    localparam int DIV   = 4;
    localparam int IDLE  = 6;
    localparam int GRANT = 6;
    localparam int XFER  = 6;
    localparam int GAP   = 5;
    localparam int TRIES = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [3:0]   req_cmd = '0;
    logic [19:0]  req_addr = '0;
    logic [3:0]   req_len = '0;
    logic [127:0] req_wdata = '0;
    logic         done;
    logic [1:0]   result;
    logic [127:0] rd_data;
    logic         chan_busy = 1'b0;
    logic         own_req;
    logic         own_gnt;
    logic         sink_present = 1'b1;
    logic [3:0]   eng_cmd;
    logic [19:0]  eng_addr;
    logic [3:0]   eng_len;
    logic         tx_we;
    logic [1:0]   tx_idx;
    logic [31:0]  tx_word;
    logic         chan_rst;
    logic         xfer_start;
    logic         xfer_busy;
    logic [7:0]   xfer_status;
    logic [1:0]   rx_idx;
    logic [31:0]  rx_word;

    always #4 clk = ~clk;

    aux_xfer_seq #(
        .TICK_DIV(DIV), .IDLE_US(IDLE), .GRANT_US(GRANT), .XFER_US(XFER),
        .GAP_US(GAP), .MAX_TRIES(TRIES)
    ) u_aux_xfer_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .done(done), .result(result), .rd_data(rd_data), .chan_busy(chan_busy),
        .own_req(own_req), .own_gnt(own_gnt), .sink_present(sink_present),
        .eng_cmd(eng_cmd), .eng_addr(eng_addr), .eng_len(eng_len),
        .tx_we(tx_we), .tx_idx(tx_idx), .tx_word(tx_word), .chan_rst(chan_rst),
        .xfer_start(xfer_start), .xfer_busy(xfer_busy), .xfer_status(xfer_status),
        .rx_idx(rx_idx), .rx_word(rx_word)
    );

    // engine model
    logic        clr_model = 1'b0;
    int          cfg_fails = 0;
    bit          cfg_hang = 1'b0;
    bit          cfg_gnt = 1'b1;
    int          cyc = 0;
    int          n_rst, n_start, n_txw, n_done, first_delta, min_gap, last_rst, fail_left;
    int          bcnt;
    bit          late_load, own_seen;
    logic [3:0]  cap_cmd, cap_len;
    logic [19:0] cap_addr;
    logic [31:0] txbuf [4];

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        own_gnt <= own_req && cfg_gnt;
        if (clr_model) begin
            n_rst <= 0; n_start <= 0; n_txw <= 0; n_done <= 0;
            first_delta <= -1; min_gap <= 1000000; last_rst <= 0;
            fail_left <= cfg_fails; late_load <= 0; own_seen <= 0;
            xfer_busy <= 0; xfer_status <= 0; bcnt <= 0;
            for (int i = 0; i < 4; i++) txbuf[i] <= '0;
        end else begin
            if (own_req) own_seen <= 1;
            if (done) n_done <= n_done + 1;
            if (tx_we) begin
                txbuf[tx_idx] <= tx_word;
                n_txw <= n_txw + 1;
                if (n_start > 0) late_load <= 1;
            end
            if (chan_rst) begin
                n_rst <= n_rst + 1; last_rst <= cyc; xfer_busy <= 0;
            end
            if (xfer_start) begin
                n_start <= n_start + 1;
                if (n_start == 0) first_delta <= cyc - last_rst;
                else if (cyc - last_rst < min_gap) min_gap <= cyc - last_rst;
                cap_cmd <= eng_cmd; cap_addr <= eng_addr; cap_len <= eng_len;
                xfer_busy <= 1; bcnt <= 3;
            end else if (xfer_busy && !cfg_hang) begin
                if (bcnt == 0) begin
                    xfer_busy <= 0;
                    xfer_status <= (fail_left > 0) ? 8'h04 : 8'h00;
                    if (fail_left > 0) fail_left <= fail_left - 1;
                end else bcnt <= bcnt - 1;
            end
        end
    end

    function automatic logic [7:0] rx_byte(input logic [19:0] a, input int b);
        return a[7:0] + 8'(b * 7) + 8'd1;
    endfunction

    always_comb
        for (int k = 0; k < 4; k++)
            rx_word[k*8 +: 8] = rx_byte(cap_addr, int'(rx_idx) * 4 + k);

    int vectors = 0;
    int misses  = 0;
    bit reported = 0;

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    endtask

    always @(posedge clk)
        if (cyc > 150000) begin
            misses++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            report();
        end

    logic [1:0]   got_res;
    logic [127:0] got_rd;
    int           lat;

    task automatic run(input logic [3:0] cmd, input logic [19:0] addr, input logic [3:0] len,
                       input logic [127:0] wd, input int fails, input bit hang,
                       input bit gnt, input bit sink, input bit busy, input bit spur);
        @(negedge clk);
        cfg_fails = fails; cfg_hang = hang; cfg_gnt = gnt;
        sink_present = sink; chan_busy = busy; clr_model = 1;
        @(negedge clk);
        clr_model = 0;
        req_cmd = cmd; req_addr = addr; req_len = len; req_wdata = wd; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        lat = 1;
        if (spur) begin
            @(negedge clk); lat++;
            req_addr = addr ^ 20'hFFFFF; req_valid = 1;
            @(negedge clk); lat++;
            req_valid = 0;
        end
        while (done !== 1'b1 && lat < 3000) begin
            @(negedge clk); lat++;
        end
        check("R12 done seen", done, 1'b1);
        got_res = result; got_rd = rd_data;
        @(negedge clk);
        check("R12 done single cycle", done, 1'b0);
        check("R11 ownership dropped", own_req, 1'b0);
        chan_busy = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset own_req", own_req, 0);
        check("R12 reset done", done, 0);
        check("R6 reset strobes", {chan_rst, xfer_start, tx_we}, 3'b000);
        rst_n = 1;

        // length sweep, write and read
        for (int l = 0; l < 16; l++) begin
            logic [127:0] wd, exp;
            logic [19:0] a;
            a = 20'h4_1000 + 20'(l * 37);
            wd = {4{32'hA5C3_0000 | 32'(l * 4097)}} ^ 128'(l);
            run(4'h8, a, 4'(l), wd, 0, 0, 1, 1, 0, 0);
            check("R9 write ok", got_res, 2'd0);
            check("R4 four words", n_txw, 4);
            check("R4 payload", {txbuf[3], txbuf[2], txbuf[1], txbuf[0]}, wd);
            check("R4 loaded before start", late_load, 0);
            check("R5 fields", {cap_cmd, cap_addr, cap_len}, {4'h8, a, 4'(l)});
            check("R7 first start", first_delta, 1);
            run(4'h9, a, 4'(l), '0, 0, 0, 1, 1, 0, 0);
            exp = '0;
            for (int b = 0; b <= l; b++) exp[b*8 +: 8] = rx_byte(a, b);
            check("R9 read ok", got_res, 2'd0);
            check("R4 read loads none", n_txw, 0);
            check("R5 read fields", {cap_cmd, cap_len}, {4'h9, 4'(l)});
            check("R10 read data", got_rd, exp);
        end

        // retry sweep
        for (int f = 0; f <= TRIES + 1; f++) begin
            int att;
            att = (f + 1 < TRIES) ? f + 1 : TRIES;
            run(4'h9, 20'h00123, 4'd5, '0, f, 0, 1, 1, 0, 0);
            check("R6 attempts", n_start, att);
            check("R6 resets", n_rst, att);
            check("R9 result", got_res, (f < TRIES) ? 2'd0 : 2'd3);
            if (att > 1) check("R7 gap", min_gap > (GAP - 1) * DIV, 1);
        end

        run(4'h8, 20'h1, 4'd3, '1, 0, 0, 1, 1, 1, 0);
        check("R1 busy result", got_res, 2'd1);
        check("R1 no ownership", own_seen, 0);
        check("R1 no attempt", n_rst + n_start, 0);
        check("R1 waited", lat >= (IDLE - 1) * DIV, 1);

        run(4'h8, 20'h2, 4'd3, '1, 0, 0, 0, 1, 0, 0);
        check("R2 busy result", got_res, 2'd1);
        check("R2 requested", own_seen, 1);
        check("R2 no attempt", n_start, 0);

        run(4'h9, 20'h3, 4'd3, '0, 0, 0, 1, 0, 0, 0);
        check("R3 nodev result", got_res, 2'd2);
        check("R3 no start", n_start, 0);

        run(4'h9, 20'h4, 4'd3, '0, 0, 1, 1, 1, 0, 0);
        check("R8 remote result", got_res, 2'd3);
        check("R8 single attempt", n_start, 1);

        run(4'h9, 20'h5_5555, 4'd7, '0, 1, 0, 1, 1, 0, 1);
        check("R12 spurious ignored addr", cap_addr, 20'h5_5555);
        check("R12 one completion", n_done, 1);
        check("R12 spurious result", got_res, 2'd0);

        report();
    end
endmodule